// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home-node controller for a group of memory lines in a cache-coherent system whose nodes talk over a point-to-point network. For every line it holds a full presence vector (one bit per node) and a modified bit. From these the line is classed as uncached (no bits), shared (clean, one or more bits) or dirty (modified, one owner bit).

Nodes send read-miss and write-miss requests. A read miss to a clean line gets a data reply from home memory. A read miss to a dirty line gets a forward reply naming the owning node, which supplies the data. The line then becomes clean and shared by the owner and the reader. A write miss sends a targeted invalidate to every other node holding the line. The controller collects one acknowledgement from each of them and only then grants the write, leaving the writer as the sole, modified holder.

The controller serves one request at a time. While a request is in flight the line is busy, and any request that arrives is refused with a negative acknowledgement on its own port so that the node retries it. The controller has five states:
- IDLE takes a request.
- REPLY answers a read.
- INVAL issues one invalidate per cycle.
- WAIT collects acknowledgements.
- GRANT releases the write.

Its transitions are:
- IDLE→REPLY on a read.
- IDLE→INVAL on a write with other holders.
- IDLE→GRANT on a write with no other holder.
- INVAL→WAIT after the last invalidate.
- WAIT→GRANT once nothing is awaited.
- REPLY→IDLE and GRANT→IDLE unconditionally.

Top module: `dirh_home_ctrl`

## Requirements
- R1: After reset no message or negative acknowledgement is issued, and every line is uncached, so the first read of any line gets a data reply.
- R2: A read miss taken in IDLE to an uncached or shared line yields a data message (kind code 0) to the requester in the next cycle, with owner field 0, and adds the requester to the line's holders.
- R3: A read miss to a dirty line yields a forward message (kind code 1) to the requester in the next cycle carrying the owner's node number in the owner field; the line then becomes clean and held by owner and requester.
- R4: A write miss sends one invalidate (kind code 2) per cycle, starting the next cycle, to every holder except the requester, in ascending node order.
- R5: The grant (kind code 3) is issued the cycle after the last awaited acknowledgement; acknowledgements from nodes not awaited have no effect.
- R6: A write miss to a line with no holder other than the requester is granted in the next cycle.
- R7: After a grant the writer is the only holder and the line is dirty, so a later read is forwarded to the writer.
- R8: A request arriving while the controller is not in IDLE is answered on the negative acknowledgement port in the next cycle with the requester and line, and it leaves the directory unchanged.
- R9: Every message carries the request's line number in its line field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_node | input | NIDW | Requesting node |
| req_line | input | LW | Line addressed |
| ack_valid | input | 1 | Invalidate acknowledgement present |
| ack_node | input | NIDW | Node acknowledging |
| out_valid | output | 1 | Outgoing message present |
| out_kind | output | 2 | 0 data, 1 forward, 2 invalidate, 3 grant |
| out_dest | output | NIDW | Destination node |
| out_owner | output | NIDW | Owner node for a forward, else 0 |
| out_line | output | LW | Line of the message |
| nack_valid | output | 1 | Negative acknowledgement present |
| nack_node | output | NIDW | Node being refused |
| nack_line | output | LW | Line of the refused request |

## Verification
Each message is timed against its stimulus. Data, forward and no-holder grant messages are due one cycle after the request edge. The k-th invalidate is due k cycles after it. A grant after invalidation is due one cycle after the edge carrying the last awaited acknowledgement. A refusal is due one cycle after the refused request. The bench places each expected message in a queue tagged with its due cycle, and a monitor sampling at the falling edge compares kind, destination, owner, line and arrival cycle. Windows in which no grant may appear, such as after a stray or partial acknowledgement, are checked by counting grants seen across those cycles.

// File: rtl/dirh_pkg.sv
package dirh_pkg;

    typedef enum logic [1:0] {
        MSG_DATA  = 2'd0,
        MSG_FWD   = 2'd1,
        MSG_INV   = 2'd2,
        MSG_GRANT = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REPLY = 3'd1,
        ST_INVAL = 3'd2,
        ST_WAIT  = 3'd3,
        ST_GRANT = 3'd4
    } ctrl_state_e;

    typedef enum logic [1:0] {
        LN_UNCACHED = 2'd0,
        LN_SHARED   = 2'd1,
        LN_DIRTY    = 2'd2
    } line_state_e;

endpackage

// File: rtl/dirh_lowbit.sv
module dirh_lowbit #(
    parameter int W  = 4,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dirh_store.sv
module dirh_store #(
    parameter int NODES = 4,
    parameter int LINES = 16,
    parameter int LW    = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    rd_line,
    output logic [NODES-1:0] rd_pres,
    output logic             rd_mod,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_line,
    input  logic [NODES-1:0] wr_pres,
    input  logic             wr_mod
);
    logic [NODES-1:0] pres_q [LINES];
    logic             mod_q  [LINES];

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pres_q[g] <= '0;
                    mod_q[g]  <= 1'b0;
                end else if (wr_en && (wr_line == LW'(g))) begin
                    pres_q[g] <= wr_pres;
                    mod_q[g]  <= wr_mod;
                end
            end
        end
    endgenerate

    assign rd_pres = pres_q[rd_line];
    assign rd_mod  = mod_q[rd_line];
endmodule

// File: rtl/dirh_ack_track.sv
module dirh_ack_track #(
    parameter int NODES = 4,
    parameter int NIDW  = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NODES-1:0] load_mask,
    input  logic             ack_valid,
    input  logic [NIDW-1:0]  ack_node,
    output logic [NODES-1:0] await_q,
    output logic [NODES-1:0] await_nxt
);
    logic [NODES-1:0] ack_bit;

    always_comb begin
        ack_bit = '0;
        if (ack_valid) ack_bit[ack_node] = 1'b1;
        await_nxt = await_q & ~ack_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    await_q <= '0;
        else if (load) await_q <= load_mask;
        else           await_q <= await_nxt;
    end
endmodule

// File: rtl/dirh_home_ctrl.sv
module dirh_home_ctrl #(
    parameter int NODES = 4,
    parameter int LINES = 16,
    parameter int NIDW  = (NODES > 1) ? $clog2(NODES) : 1,
    parameter int LW    = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [NIDW-1:0] req_node,
    input  logic [LW-1:0]   req_line,
    input  logic            ack_valid,
    input  logic [NIDW-1:0] ack_node,
    output logic            out_valid,
    output logic [1:0]      out_kind,
    output logic [NIDW-1:0] out_dest,
    output logic [NIDW-1:0] out_owner,
    output logic [LW-1:0]   out_line,
    output logic            nack_valid,
    output logic [NIDW-1:0] nack_node,
    output logic [LW-1:0]   nack_line
);
    import dirh_pkg::*;

    ctrl_state_e      st_q, st_d;
    logic             ctrl_idle, accept;
    logic [NIDW-1:0]  cur_node;
    logic [LW-1:0]    cur_line;
    logic [NODES-1:0] cur_pres;
    logic             cur_dirty;
    logic [NODES-1:0] todo_q;
    line_state_e      cur_lstate;

    // directory storage
    logic [LW-1:0]    rd_line;
    logic [NODES-1:0] rd_pres;
    logic             rd_mod;
    logic             wr_en;
    logic [NODES-1:0] wr_pres;
    logic             wr_mod;

    // helpers
    logic [NODES-1:0] req_bit, cur_bit, owner_bit, pick_bit, targets;
    logic [NIDW-1:0]  owner_idx, pick_idx;
    logic             owner_found, pick_found;
    logic [NODES-1:0] await_q, await_nxt;
    logic             trk_load;

    assign ctrl_idle = (st_q == ST_IDLE);
    assign accept    = req_valid && ctrl_idle;
    assign rd_line   = ctrl_idle ? req_line : cur_line;

    always_comb begin
        req_bit = '0;
        req_bit[req_node] = 1'b1;
        cur_bit = '0;
        cur_bit[cur_node] = 1'b1;
        owner_bit = '0;
        owner_bit[owner_idx] = owner_found;
        pick_bit = '0;
        pick_bit[pick_idx] = pick_found;
        targets = rd_pres & ~req_bit;
    end

    dirh_store #(.NODES(NODES), .LINES(LINES), .LW(LW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_line (rd_line),
        .rd_pres (rd_pres),
        .rd_mod  (rd_mod),
        .wr_en   (wr_en),
        .wr_line (cur_line),
        .wr_pres (wr_pres),
        .wr_mod  (wr_mod)
    );

    dirh_lowbit #(.W(NODES), .IW(NIDW)) u_owner_pick (
        .vec   (cur_pres),
        .idx   (owner_idx),
        .found (owner_found)
    );

    dirh_lowbit #(.W(NODES), .IW(NIDW)) u_inv_pick (
        .vec   (todo_q),
        .idx   (pick_idx),
        .found (pick_found)
    );

    assign trk_load = accept && req_write;

    dirh_ack_track #(.NODES(NODES), .NIDW(NIDW)) u_acks (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .load_mask (targets),
        .ack_valid (ack_valid),
        .ack_node  (ack_node),
        .await_q   (await_q),
        .await_nxt (await_nxt)
    );

    // line class of the request in flight
    always_comb begin
        if (cur_dirty)          cur_lstate = LN_DIRTY;
        else if (cur_pres != 0) cur_lstate = LN_SHARED;
        else                    cur_lstate = LN_UNCACHED;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write)        st_d = ST_REPLY;
                    else if (targets != 0) st_d = ST_INVAL;
                    else                   st_d = ST_GRANT;
                end
            end
            ST_REPLY: st_d = ST_IDLE;
            ST_INVAL: if ((todo_q & ~pick_bit) == 0) st_d = ST_WAIT;
            ST_WAIT:  if (await_nxt == 0) st_d = ST_GRANT;
            ST_GRANT: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // request context and invalidate worklist
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_node  <= '0;
            cur_line  <= '0;
            cur_pres  <= '0;
            cur_dirty <= 1'b0;
            todo_q    <= '0;
        end else if (accept) begin
            cur_node  <= req_node;
            cur_line  <= req_line;
            cur_pres  <= rd_pres;
            cur_dirty <= rd_mod;
            todo_q    <= req_write ? targets : '0;
        end else if (st_q == ST_INVAL) begin
            todo_q    <= todo_q & ~pick_bit;
        end
    end

    // refusals while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nack_valid <= 1'b0;
            nack_node  <= '0;
            nack_line  <= '0;
        end else begin
            nack_valid <= req_valid && !ctrl_idle;
            nack_node  <= req_node;
            nack_line  <= req_line;
        end
    end

    // outputs and directory update
    always_comb begin
        out_valid = 1'b0;
        out_kind  = MSG_DATA;
        out_dest  = cur_node;
        out_owner = '0;
        out_line  = cur_line;
        wr_en     = 1'b0;
        wr_pres   = cur_pres;
        wr_mod    = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_REPLY: begin
                out_valid = 1'b1;
                wr_en     = 1'b1;
                if (cur_lstate == LN_DIRTY) begin
                    out_kind  = MSG_FWD;
                    out_owner = owner_idx;
                    wr_pres   = owner_bit | cur_bit;
                end else begin
                    out_kind  = MSG_DATA;
                    wr_pres   = cur_pres | cur_bit;
                end
            end
            ST_INVAL: begin
                out_valid = 1'b1;
                out_kind  = MSG_INV;
                out_dest  = pick_idx;
            end
            ST_WAIT: ;
            ST_GRANT: begin
                out_valid = 1'b1;
                out_kind  = MSG_GRANT;
                wr_en     = 1'b1;
                wr_pres   = cur_bit;
                wr_mod    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dirh_home_chk.sv
module dirh_home_chk #(
    parameter int NODES = 4,
    parameter int NIDW  = (NODES > 1) ? $clog2(NODES) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic [NIDW-1:0] req_node,
    input logic            ctrl_idle,
    input logic [NIDW-1:0] cur_node,
    input logic            out_valid,
    input logic [1:0]      out_kind,
    input logic [NIDW-1:0] out_dest,
    input logic            nack_valid,
    input logic [NIDW-1:0] nack_node
);
    // R2 / R3: a read taken in IDLE is answered next cycle
    a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctrl_idle && !req_write) |=>
            (out_valid && out_kind[1] == 1'b0 && out_dest == $past(req_node)));

    // R4 / R6: a write taken in IDLE starts invalidating or grants next cycle
    a_r4_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctrl_idle && req_write) |=> (out_valid && out_kind[1] == 1'b1));

    // R4: never invalidate the writer itself
    a_r4_inv_not_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd2) |-> (out_dest != cur_node));

    // R8: busy controller refuses next cycle
    a_r8_nack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ctrl_idle) |=> (nack_valid && nack_node == $past(req_node)));

    // R8: no refusal for a request taken in IDLE
    a_r8_no_nack_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctrl_idle) |=> !nack_valid);
endmodule

bind dirh_home_ctrl dirh_home_chk #(.NODES(NODES), .NIDW(NIDW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_node   (req_node),
    .ctrl_idle  (ctrl_idle),
    .cur_node   (cur_node),
    .out_valid  (out_valid),
    .out_kind   (out_kind),
    .out_dest   (out_dest),
    .nack_valid (nack_valid),
    .nack_node  (nack_node)
);

// File: tb/tb_dirh_home_ctrl.sv
module tb_dirh_home_ctrl;
    localparam int NODES = 4;
    localparam int LINES = 16;
    localparam int NIDW  = 2;
    localparam int LW    = 4;
    localparam int K_DATA = 0, K_FWD = 1, K_INV = 2, K_GRANT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [NIDW-1:0] req_node = '0;
    logic [LW-1:0]   req_line = '0;
    logic ack_valid = 1'b0;
    logic [NIDW-1:0] ack_node = '0;
    logic out_valid, nack_valid;
    logic [1:0] out_kind;
    logic [NIDW-1:0] out_dest, out_owner, nack_node;
    logic [LW-1:0] out_line, nack_line;

    always #10 clk = ~clk;

    dirh_home_ctrl #(.NODES(NODES), .LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_node(req_node), .req_line(req_line),
        .ack_valid(ack_valid), .ack_node(ack_node),
        .out_valid(out_valid), .out_kind(out_kind), .out_dest(out_dest),
        .out_owner(out_owner), .out_line(out_line),
        .nack_valid(nack_valid), .nack_node(nack_node), .nack_line(nack_line)
    );

    typedef struct {
        int    kind;
        int    dest;
        int    owner;
        int    line;
        int    due;
        string tag;
    } exp_t;

    exp_t msg_q[$];
    exp_t nack_q[$];
    int total = 0, bad = 0, cyc = 0, grants_seen = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitors (scoreboard side)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (out_kind == 2'd3) grants_seen++;
            if (msg_q.size() == 0) begin
                check(1'b0, "R9", "unexpected message kind", int'(out_kind), -1);
            end else begin
                exp_t e;
                e = msg_q.pop_front();
                check(int'(out_kind) == e.kind, e.tag, "kind", int'(out_kind), e.kind);
                check(int'(out_dest) == e.dest, e.tag, "dest", int'(out_dest), e.dest);
                check(int'(out_owner) == e.owner, e.tag, "owner", int'(out_owner), e.owner);
                check(int'(out_line) == e.line, "R9", "line", int'(out_line), e.line);
                check(cyc == e.due, e.tag, "cycle", cyc, e.due);
            end
        end
        if (rst_n && nack_valid) begin
            if (nack_q.size() == 0) begin
                check(1'b0, "R8", "unexpected nack node", int'(nack_node), -1);
            end else begin
                exp_t e;
                e = nack_q.pop_front();
                check(int'(nack_node) == e.dest && int'(nack_line) == e.line, e.tag,
                      "nack node", int'(nack_node), e.dest);
                check(cyc == e.due, e.tag, "nack cycle", cyc, e.due);
            end
        end
    end

    task automatic expect_msg(input int kind, input int dest, input int owner, input int line,
                              input int due, input string tag);
        exp_t e;
        e.kind = kind; e.dest = dest; e.owner = owner; e.line = line; e.due = due; e.tag = tag;
        msg_q.push_back(e);
    endtask

    task automatic expect_nack(input int dest, input int line, input int due);
        exp_t e;
        e.kind = 0; e.dest = dest; e.owner = 0; e.line = line; e.due = due; e.tag = "R8";
        nack_q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: called at a falling edge, returns one falling edge later
    task automatic issue(input int node, input int line, input bit wr);
        req_valid = 1'b1; req_write = wr;
        req_node = NIDW'(node); req_line = LW'(line);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_ack(input int node);
        ack_valid = 1'b1; ack_node = NIDW'(node);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic do_read(input int node, input int line, input int kind, input int owner,
                           input string tag);
        expect_msg(kind, node, owner, line, cyc + 1, tag);
        issue(node, line, 1'b0);
        tick(2);
    endtask

    initial begin
        int g0;
        tick(3);
        // R1: quiet during and after reset
        check(!out_valid && !nack_valid, "R1", "out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;
        tick(2);
        check(!out_valid && !nack_valid, "R1", "idle outputs", int'(out_valid), 0);

        // R1 R2: first reads of an untouched line get data
        do_read(0, 3, K_DATA, 0, "R1");
        do_read(2, 3, K_DATA, 0, "R2");

        // R4 R5 R8: write by node 1, holders 0 and 2 invalidated in order
        expect_msg(K_INV, 0, 0, 3, cyc + 1, "R4");
        expect_msg(K_INV, 2, 0, 3, cyc + 2, "R4");
        issue(1, 3, 1'b1);
        tick(3);
        g0 = grants_seen;
        send_ack(3);             // R5: node 3 was not invalidated
        tick(2);
        check(grants_seen == g0, "R5", "grant after stray ack", grants_seen, g0);
        send_ack(0);
        tick(2);
        check(grants_seen == g0, "R5", "grant after partial ack", grants_seen, g0);
        expect_nack(3, 9, cyc + 1);   // R8: busy refusal
        issue(3, 9, 1'b0);
        tick(1);
        expect_msg(K_GRANT, 1, 0, 3, cyc + 1, "R5");
        send_ack(2);
        tick(2);
        check(grants_seen == g0 + 1, "R5", "grant count", grants_seen, g0 + 1);

        // R7 R3: dirty line forwarded to owner 1, then clean
        do_read(0, 3, K_FWD, 1, "R7");
        do_read(2, 3, K_DATA, 0, "R3");

        // R4: holders {0,1,2}, writer 2 -> invalidate 0 then 1
        expect_msg(K_INV, 0, 0, 3, cyc + 1, "R4");
        expect_msg(K_INV, 1, 0, 3, cyc + 2, "R4");
        issue(2, 3, 1'b1);
        tick(3);
        send_ack(1);
        expect_msg(K_GRANT, 2, 0, 3, cyc + 1, "R5");
        send_ack(0);
        tick(2);

        // R6: writer is the sole owner already
        expect_msg(K_GRANT, 2, 0, 3, cyc + 1, "R6");
        issue(2, 3, 1'b1);
        tick(2);

        // R8: refused read of line 9 left it uncached -> immediate grant
        expect_msg(K_GRANT, 3, 0, 9, cyc + 1, "R8");
        issue(3, 9, 1'b1);
        tick(2);
        do_read(1, 9, K_FWD, 3, "R7");

        // R2 R6: top line, and a sole sharer upgrading
        do_read(1, 15, K_DATA, 0, "R2");
        do_read(0, 0, K_DATA, 0, "R2");
        expect_msg(K_GRANT, 0, 0, 0, cyc + 1, "R6");
        issue(0, 0, 1'b1);
        tick(3);

        check(msg_q.size() == 0, "R9", "messages outstanding", msg_q.size(), 0);
        check(nack_q.size() == 0, "R8", "nacks outstanding", nack_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule